// File: doc/BRIEF.md
# Sticky Event Status and Interrupt Mask Unit

This unit sits beside a serial-memory controller and turns the controller's single-cycle event pulses into sticky status flags. Software reads the flags through a small register port. A read of the status register returns the flags and clears the sticky ones. A flag whose event pulses in the same cycle as that read stays set, so no event is lost.

Two status positions are not sticky. They show live level inputs: the chip-select state and the controller-enabled state. An interrupt mask is changed only through a write-one-to-set register and a write-one-to-clear register, and a fourth register reads the mask back. The single interrupt line is high whenever any status bit is set together with its mask bit.

Which bit positions are sticky and which are live is set by parameters. Positions that are neither always read as zero and cannot be masked in.

Top module: `ssr_irq_unit`

## Requirements
- R1: After reset, every sticky flag and every mask bit is zero and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i` at a sticky position sets that status flag from the next cycle. Sticky positions by default: 0 receive-full, 1 transmit-empty, 2 transmit-idle, 3 overrun, 8 chip-select-rise, 10 instruction-end. The flag then stays set until the status register is read.
- R3: A read of the status register (offset 0x10) returns the flags in that same cycle on `reg_rdata`, and the sticky flags read as zero from the next cycle on.
- R4: An event pulse in the same cycle as a status read leaves that flag set after the read.
- R5: Status bit 9 follows `lvl_i[9]` and bit 24 follows `lvl_i[24]` in the same cycle. A status read does not clear them.
- R6: Writing to offset 0x14 sets each implemented mask bit whose write-data bit is one. Zero bits leave the mask unchanged.
- R7: Writing to offset 0x18 clears each mask bit whose write-data bit is one. Zero bits leave the mask unchanged.
- R8: A read of offset 0x1C returns the mask. Writes to 0x10 or 0x1C change neither the flags nor the mask.
- R9: `irq_o` is high exactly when some status bit and its mask bit are both one. It follows the registered state combinationally, without added latency.
- R10: Positions that are neither sticky nor live read as zero in both the status and the mask registers, whatever the events, levels or enable writes.
- R11: `reg_rdata` is zero when `reg_re` is low or when the address matches none of the four registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | DATA_W (32) | Single-cycle event pulses, one per status position |
| lvl_i | input | DATA_W (32) | Level inputs for the live status positions |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_re | input | 1 | Read strobe; a status read clears the sticky flags |
| reg_rdata | output | DATA_W (32) | Read data, valid in the same cycle as `reg_re` |
| irq_o | output | 1 | Level interrupt line |

## Verification
A sticky flag stuck at one, or one that misses its clear, shows up on the next status read as an extra one bit. If that bit is masked in, `irq_o` also stays high one cycle after the read. A lost coincident event shows up on the very next read as a missing bit. A mask update that drops or leaks a bit shows up the following cycle on a read of 0x1C, and on `irq_o` as soon as the matching flag sets. The bench therefore reads back after every stimulus and checks `irq_o` in each cycle, so that a fault becomes visible within one or two cycles of its cause.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   // Status bit positions; software decodes these.
   localparam int B_RX_FULL  = 0;
   localparam int B_TX_EMPTY = 1;
   localparam int B_TX_IDLE  = 2;
   localparam int B_OVERRUN  = 3;
   localparam int B_CS_RISE  = 8;
   localparam int B_CS_LVL   = 9;
   localparam int B_INST_END = 10;
   localparam int B_ENABLED  = 24;

   localparam logic [31:0] STICKY_DFLT = (32'd1 << B_RX_FULL) | (32'd1 << B_TX_EMPTY)
                                       | (32'd1 << B_TX_IDLE) | (32'd1 << B_OVERRUN)
                                       | (32'd1 << B_CS_RISE) | (32'd1 << B_INST_END);
   localparam logic [31:0] LIVE_DFLT   = (32'd1 << B_CS_LVL) | (32'd1 << B_ENABLED);

   // Register byte offsets
   localparam logic [7:0] OFS_STAT = 8'h10;
   localparam logic [7:0] OFS_MSET = 8'h14;
   localparam logic [7:0] OFS_MCLR = 8'h18;
   localparam logic [7:0] OFS_MASK = 8'h1C;

   typedef enum logic [2:0] {SEL_NONE, SEL_STAT, SEL_MSET, SEL_MCLR, SEL_MASK} reg_sel_e;
endpackage

// File: rtl/ssr_sticky_bank.sv
module ssr_sticky_bank #(
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] STICKY_MASK = '1,
   parameter logic [DATA_W-1:0] LIVE_MASK   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_i,
   input  logic [DATA_W-1:0] lvl_i,
   input  logic              rd_clr_i,
   output logic [DATA_W-1:0] view_o
);
   logic [DATA_W-1:0] evt_s;
   logic [DATA_W-1:0] live_v;
   logic [DATA_W-1:0] sticky_q;

   assign evt_s  = evt_i & STICKY_MASK;
   assign live_v = lvl_i & LIVE_MASK;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (STICKY_MASK[i]) begin : g_sticky
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= (flag_q & ~rd_clr_i) | evt_s[i];
         end
         assign sticky_q[i] = flag_q;
         assign view_o[i]   = flag_q;
      end else if (LIVE_MASK[i]) begin : g_live
         assign sticky_q[i] = 1'b0;
         assign view_o[i]   = live_v[i];
      end else begin : g_none
         assign sticky_q[i] = 1'b0;
         assign view_o[i]   = 1'b0;
      end
   end

   // R3
   sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i && evt_s == '0) |=> sticky_q == '0);
   // R4
   evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_s != '0) |=> ((sticky_q & $past(evt_s)) == $past(evt_s)));
endmodule

// File: rtl/ssr_mask_reg.sv
module ssr_mask_reg #(
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we_i,
   input  logic              clr_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] mask_o
);
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] wd_impl;
   logic [DATA_W-1:0] set_v;
   logic [DATA_W-1:0] clr_v;

   assign wd_impl = wdata_i & IMPL_MASK;
   assign set_v   = set_we_i ? wd_impl : '0;
   assign clr_v   = clr_we_i ? wd_impl : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   mask_q <= '0;
      else if (set_we_i || clr_we_i) mask_q <= (mask_q | set_v) & ~clr_v;
   end

   assign mask_o = mask_q;

   // R6
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we_i && !clr_we_i) |=> ((mask_q & $past(wd_impl)) == $past(wd_impl)));
   // R7
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_i |=> ((mask_q & $past(wdata_i)) == '0));
   // R8
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_we_i || clr_we_i) |=> $stable(mask_q));
endmodule

// File: rtl/ssr_irq_unit.sv
module ssr_irq_unit #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter logic [DATA_W-1:0] STICKY_MASK = DATA_W'(ssr_pkg::STICKY_DFLT),
   parameter logic [DATA_W-1:0] LIVE_MASK   = DATA_W'(ssr_pkg::LIVE_DFLT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_i,
   input  logic [DATA_W-1:0] lvl_i,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_re,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);
   import ssr_pkg::*;

   localparam logic [DATA_W-1:0] IMPL_MASK = STICKY_MASK | LIVE_MASK;

   if (DATA_W < B_ENABLED + 1) begin : g_bad_width
      $error("DATA_W too small for the status layout");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must hold the register offsets");
   end
   if ((STICKY_MASK & LIVE_MASK) != '0) begin : g_bad_masks
      $error("a position cannot be both sticky and live");
   end

   reg_sel_e          sel;
   logic [DATA_W-1:0] stat_view;
   logic [DATA_W-1:0] mask_v;

   always_comb begin
      unique case (reg_addr)
         ADDR_W'(OFS_STAT): sel = SEL_STAT;
         ADDR_W'(OFS_MSET): sel = SEL_MSET;
         ADDR_W'(OFS_MCLR): sel = SEL_MCLR;
         ADDR_W'(OFS_MASK): sel = SEL_MASK;
         default:           sel = SEL_NONE;
      endcase
   end

   ssr_sticky_bank #(
      .DATA_W(DATA_W), .STICKY_MASK(STICKY_MASK), .LIVE_MASK(LIVE_MASK)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lvl_i(lvl_i),
      .rd_clr_i(reg_re && sel == SEL_STAT), .view_o(stat_view)
   );

   ssr_mask_reg #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .set_we_i(reg_we && sel == SEL_MSET),
      .clr_we_i(reg_we && sel == SEL_MCLR),
      .wdata_i(reg_wdata), .mask_o(mask_v)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_re) begin
         case (sel)
            SEL_STAT: reg_rdata = stat_view;
            SEL_MASK: reg_rdata = mask_v;
            default:  reg_rdata = '0;
         endcase
      end
   end

   assign irq_o = |(stat_view & mask_v);

   // R10
   impl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_view | mask_v) & ~IMPL_MASK) == '0);
endmodule

// File: tb/sim_ssr_irq_unit.sv
module sim_ssr_irq_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 23;
   // {req[3:0], op[1:0] (0 idle, 1 write, 2 read), addr[7:0], wdata, evt, exp_rdata, exp_irq}
   localparam logic [110:0] TBL [NV] = '{
      {4'd1,  2'd2, 8'h10, 32'h0,        32'h0,        32'h0,        1'b0}, // R1
      {4'd1,  2'd2, 8'h1C, 32'h0,        32'h0,        32'h0,        1'b0}, // R1
      {4'd2,  2'd0, 8'h00, 32'h0,        32'h00000009, 32'h0,        1'b0}, // R2
      {4'd2,  2'd2, 8'h10, 32'h0,        32'h0,        32'h00000009, 1'b0}, // R2
      {4'd3,  2'd2, 8'h10, 32'h0,        32'h0,        32'h0,        1'b0}, // R3
      {4'd6,  2'd1, 8'h14, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b0}, // R6
      {4'd10, 2'd2, 8'h1C, 32'h0,        32'h0,        32'h0100070F, 1'b0}, // R10
      {4'd7,  2'd1, 8'h18, 32'h00000700, 32'h0,        32'h0,        1'b0}, // R7
      {4'd7,  2'd2, 8'h1C, 32'h0,        32'h0,        32'h0100000F, 1'b0}, // R7
      {4'd9,  2'd0, 8'h00, 32'h0,        32'h00000400, 32'h0,        1'b0}, // R9
      {4'd9,  2'd0, 8'h00, 32'h0,        32'h0,        32'h0,        1'b0}, // R9
      {4'd6,  2'd1, 8'h14, 32'h00000400, 32'h0,        32'h0,        1'b0}, // R6
      {4'd9,  2'd0, 8'h00, 32'h0,        32'h0,        32'h0,        1'b1}, // R9
      {4'd4,  2'd2, 8'h10, 32'h0,        32'h00000002, 32'h00000400, 1'b1}, // R4
      {4'd4,  2'd2, 8'h10, 32'h0,        32'h0,        32'h00000002, 1'b1}, // R4
      {4'd3,  2'd0, 8'h00, 32'h0,        32'h0,        32'h0,        1'b0}, // R3
      {4'd8,  2'd1, 8'h10, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b0}, // R8
      {4'd8,  2'd2, 8'h1C, 32'h0,        32'h0,        32'h0100040F, 1'b0}, // R8
      {4'd8,  2'd1, 8'h1C, 32'h0,        32'h0,        32'h0,        1'b0}, // R8
      {4'd8,  2'd2, 8'h1C, 32'h0,        32'h0,        32'h0100040F, 1'b0}, // R8
      {4'd11, 2'd2, 8'h20, 32'h0,        32'h00000020, 32'h0,        1'b0}, // R11
      {4'd10, 2'd2, 8'h10, 32'h0,        32'h0,        32'h0,        1'b0}, // R10
      {4'd11, 2'd0, 8'h1C, 32'h0,        32'h0,        32'h0,        1'b0}  // R11
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt_i = '0;
   logic [31:0] lvl_i = '0;
   logic [7:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_re = 1'b0;
   logic [31:0] reg_rdata;
   logic        irq_o;
   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ssr_irq_unit u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lvl_i(lvl_i),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_re(reg_re), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   task automatic cmp(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // Drive one cycle at the falling edge; outputs are sampled 1 time unit later.
   task automatic step(input logic [1:0] op, input logic [7:0] a, input logic [31:0] wd,
                       input logic [31:0] ev);
      @(negedge clk);
      reg_we = (op == 2'd1); reg_re = (op == 2'd2);
      reg_addr = a; reg_wdata = wd; evt_i = ev;
      #1;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp(1, "irq in reset", {31'd0, irq_o}, 32'd0); // R1
      rst_n = 1'b1;
      for (int k = 0; k < NV; k++) begin
         logic [110:0] v;
         v = TBL[k];
         step(v[106:105], v[104:97], v[96:65], v[64:33]);
         if (v[106:105] == 2'd2) cmp(int'(v[110:107]), "rdata", reg_rdata, v[32:1]);
         cmp(int'(v[110:107]), "irq", {31'd0, irq_o}, {31'd0, v[0]});
      end
      // R2 / R10: each position pulsed alone, then read back
      for (int b = 0; b < 32; b++) begin
         logic [31:0] e;
         e = (32'h0000050F >> b) & 32'd1 ? (32'd1 << b) : 32'd0;
         step(2'd0, 8'h00, 32'h0, 32'd1 << b);
         step(2'd2, 8'h10, 32'h0, 32'h0);
         cmp(2, "single event", reg_rdata, e);
      end
      // R5: live bits follow levels and survive reads
      @(negedge clk); lvl_i = 32'h01000200;
      step(2'd2, 8'h10, 32'h0, 32'h0);
      cmp(5, "live read", reg_rdata, 32'h01000200);
      cmp(9, "irq live enabled", {31'd0, irq_o}, 32'd1);
      step(2'd2, 8'h10, 32'h0, 32'h0);
      cmp(5, "live reread", reg_rdata, 32'h01000200);
      lvl_i = 32'h00000200; #1;
      cmp(9, "irq masked live", {31'd0, irq_o}, 32'd0);
      step(2'd2, 8'h10, 32'h0, 32'h0);
      cmp(5, "live follows", reg_rdata, 32'h00000200);
      lvl_i = '0;
      // R1: reset mid-run clears flags and mask
      step(2'd0, 8'h00, 32'h0, 32'h00000401);
      step(2'd0, 8'h00, 32'h0, 32'h0);
      cmp(9, "irq before reset", {31'd0, irq_o}, 32'd1);
      rst_n = 1'b0; #1;
      cmp(1, "irq async reset", {31'd0, irq_o}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      step(2'd2, 8'h10, 32'h0, 32'h0);
      cmp(1, "status after reset", reg_rdata, 32'h0);
      step(2'd2, 8'h1C, 32'h0, 32'h0);
      cmp(1, "mask after reset", reg_rdata, 32'h0);
      // R11: read strobe low gives zero even at mask address
      step(2'd1, 8'h14, 32'h1, 32'h0);
      step(2'd0, 8'h1C, 32'h0, 32'h0);
      cmp(11, "no read strobe", reg_rdata, 32'h0);
      step(2'd0, 8'h00, 32'h0, 32'h0);
      finish_run();
   end
endmodule